// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block runs single read and write transfers on an external bus whose low address byte and data byte travel on one shared 8-bit port. A requester offers a 16-bit address, a direction flag, a data-space or program-space select, write data and a flag that asks for slow timing. The sequencer then produces the whole transfer. It drives the high address byte on a dedicated port. It shows the low address byte on the shared port and marks it with a short low pulse on the address strobe. It then turns the shared port around and lowers the data strobe for a fixed number of clocks. On a read it captures the returned byte when the data strobe goes high.

Each transfer passes through six named states: `ST_IDLE`, `ST_ADDR`, `ST_ASLO`, `ST_TURN`, `ST_DSLO` and `ST_HOLD`. The transitions are as follows:
- `ST_IDLE` moves to `ST_ADDR` when a request is accepted.
- `ST_ADDR` moves to `ST_ASLO`, and `ST_ASLO` moves to `ST_TURN`.
- `ST_TURN` moves to `ST_DSLO` and loads the strobe-length counter.
- `ST_DSLO` stays where it is until that counter reaches zero, then moves to `ST_HOLD`.
- `ST_HOLD` moves back to `ST_IDLE` unconditionally.

All timing is counted in whole clock periods. Both strobes are active low and rest high.

Top module: `mxbus_seq`

## Requirements
- R1: Reset state. During and after reset with no request, the outputs are as follows: `as_n`=1, `ds_n`=1, `ad_oe`=0, `rw_n`=1, `dsel`=0, `addr_hi`=0, `done`=0 and `req_ready`=1.
- R2: Address phase. In the first clock after acceptance, `ad_oe`=1, `ad_out`=address[7:0], `addr_hi`=address[15:8] and `as_n`=1. In the next clock `as_n` is 0 for exactly one clock, with the address still driven on the shared port.
- R3: Direction and space select. `rw_n` (1 = read, 0 = write) and `dsel` (1 = data space, 0 = program space) are valid from the address phase onward. They stay unchanged until the sequencer returns to idle, which is one clock after the data strobe rises.
- R4: Read turnaround. On a read, `ad_oe` is 0 from the clock in which `as_n` rises until the end of the transfer. `ds_n` falls one clock after `as_n` rises.
- R5: Write data. On a write, `ad_out` equals the write data and `ad_oe`=1 from the clock in which `as_n` rises through the clock after `ds_n` rises.
- R6: Data strobe length. `ds_n` stays low for 2 clocks on a read and 1 clock on a write. When the extended flag is set, it stays low for 2 more clocks.
- R7: Read capture. `rd_data` takes the value on `ad_in` at the clock edge on which `ds_n` rises. It keeps that value until the next read capture.
- R8: Completion. `done` is 1 for exactly one clock, the clock right after `ds_n` rises. `req_ready` is 0 from acceptance until the clock after `done`.
- R9: Busy protection. `req_valid` while `req_ready`=0 is ignored and starts no extra transfer. `as_n` is never low while `ds_n` is low.
- R10: High address. `addr_hi` holds address[15:8] for the whole transfer, from the address phase through the clock after `ds_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, a request is accepted this clock |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dmem | input | 1 | 1 = data space, 0 = program space |
| req_wdata | input | 8 | Write data |
| req_ext | input | 1 | Lengthen the data strobe |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read byte |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | 1 = read, 0 = write |
| dsel | output | 1 | 1 = data space, 0 = program space |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |

## Verification
Several properties are checked on every clock:
- the two strobes never overlap, and the address strobe pulse lasts one clock;
- the shared port is released during a read strobe and driven during a write strobe;
- direction, space select and high address stay stable through each transfer;
- the data strobe length matches the direction and the extended flag;
- `done` lines up with the rise of the data strobe.

Some behaviours can only be shown by the bench scenarios. These include the correct address byte on the shared port, the byte captured from a memory model, write data reaching that model, and requests being ignored while busy.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_ASLO = 3'd2,
        ST_TURN = 3'd3,
        ST_DSLO = 3'd4,
        ST_HOLD = 3'd5
    } seq_state_e;

endpackage

// File: rtl/mxbus_dscnt.sv
module mxbus_dscnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/mxbus_rdcap.sv
module mxbus_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (cap) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int RD_DS_CLKS = 2,
    parameter int WR_DS_CLKS = 1,
    parameter int EXT_CLKS   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 req_dmem,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 req_ext,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 as_n,
    output logic                 ds_n,
    output logic                 rw_n,
    output logic                 dsel,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    input  logic [DATA_W-1:0]    ad_in
);
    localparam int HI_W    = ADDR_W - DATA_W;
    localparam int MAX_LEN = ((RD_DS_CLKS > WR_DS_CLKS) ? RD_DS_CLKS : WR_DS_CLKS) + EXT_CLKS;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              dmem;
        logic              ext;
    } req_t;

    seq_state_e state_q, state_d;
    req_t       req_q;
    logic       accept;
    logic       cnt_load, cnt_dec, cnt_zero, cap;
    logic [CNT_W-1:0] len_m1;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= '{addr: req_addr, wdata: req_wdata, write: req_write,
                       dmem: req_dmem, ext: req_ext};
        end
    end

    always_comb begin
        int len;
        len = req_q.write ? WR_DS_CLKS : RD_DS_CLKS;
        if (req_q.ext) len = len + EXT_CLKS;
        len_m1 = CNT_W'(len - 1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_ASLO;
            ST_ASLO: state_d = ST_TURN;
            ST_TURN: state_d = ST_DSLO;
            ST_DSLO: if (cnt_zero) state_d = ST_HOLD;
            ST_HOLD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt_load = (state_q == ST_TURN);
    assign cnt_dec  = (state_q == ST_DSLO);
    assign cap      = (state_q == ST_DSLO) && cnt_zero && !req_q.write;

    mxbus_dscnt #(.CNT_W(CNT_W)) dscnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (len_m1),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    mxbus_rdcap #(.DATA_W(DATA_W)) rdcap_i (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (cap),
        .din  (ad_in),
        .dout (rd_data)
    );

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        as_n      = 1'b1;
        ds_n      = 1'b1;
        rw_n      = 1'b1;
        dsel      = 1'b0;
        addr_hi   = '0;
        ad_out    = '0;
        ad_oe     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_ADDR, ST_ASLO: begin
                as_n    = (state_q != ST_ASLO);
                rw_n    = !req_q.write;
                dsel    = req_q.dmem;
                addr_hi = req_q.addr[ADDR_W-1:DATA_W];
                ad_out  = req_q.addr[DATA_W-1:0];
                ad_oe   = 1'b1;
            end
            ST_TURN, ST_DSLO, ST_HOLD: begin
                ds_n    = (state_q != ST_DSLO);
                done    = (state_q == ST_HOLD);
                rw_n    = !req_q.write;
                dsel    = req_q.dmem;
                addr_hi = req_q.addr[ADDR_W-1:DATA_W];
                ad_out  = req_q.write ? req_q.wdata : '0;
                ad_oe   = req_q.write;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;
endmodule

// File: rtl/mxbus_seq_chk.sv
module mxbus_seq_chk #(
    parameter int RD_DS_CLKS = 2,
    parameter int WR_DS_CLKS = 1,
    parameter int EXT_CLKS   = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic       req_ext,
    input logic       done,
    input logic       as_n,
    input logic       ds_n,
    input logic       rw_n,
    input logic       dsel,
    input logic [7:0] addr_hi,
    input logic       ad_oe
);
    logic [7:0] lo_cnt, exp_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            exp_len <= '0;
        end else begin
            if (!ds_n) lo_cnt <= lo_cnt + 8'd1;
            else if (req_valid && req_ready) lo_cnt <= '0;
            if (req_valid && req_ready)
                exp_len <= 8'((req_write ? WR_DS_CLKS : RD_DS_CLKS) + (req_ext ? EXT_CLKS : 0));
        end
    end

    // R9
    strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> as_n);

    // R2
    as_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);

    // R2
    as_addr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> ad_oe);

    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw_n) |-> !ad_oe);

    // R5
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rw_n) |-> ad_oe);

    // R3
    ctl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(rw_n) && $stable(dsel)));

    // R10
    hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(addr_hi));

    // R6
    ds_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> (lo_cnt == exp_len));

    // R8
    done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(ds_n));

    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));
endmodule

bind mxbus_seq mxbus_seq_chk #(
    .RD_DS_CLKS(RD_DS_CLKS),
    .WR_DS_CLKS(WR_DS_CLKS),
    .EXT_CLKS  (EXT_CLKS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_ext  (req_ext),
    .done     (done),
    .as_n     (as_n),
    .ds_n     (ds_n),
    .rw_n     (rw_n),
    .dsel     (dsel),
    .addr_hi  (addr_hi),
    .ad_oe    (ad_oe)
);

// File: tb/mxbus_seq_tb.sv
module mxbus_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [15:0] req_addr = '0;
    logic       req_write = 1'b0;
    logic       req_dmem = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       req_ext = 1'b0;
    logic       done;
    logic [7:0] rd_data;
    logic       as_n, ds_n, rw_n, dsel, ad_oe;
    logic [7:0] addr_hi, ad_out;
    logic [7:0] ad_in = '0;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    int issued = 0;
    int as_falls = 0;
    bit finished = 0;

    typedef struct {
        bit         write;
        bit         dmem;
        logic [15:0] addr;
        logic [7:0] data;
        int         dslen;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    mxbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_dmem(req_dmem),
        .req_wdata(req_wdata), .req_ext(req_ext), .done(done), .rd_data(rd_data),
        .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dsel(dsel), .addr_hi(addr_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input bit dm, input logic [15:0] a,
                          input logic [7:0] wd, input bit ext);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_dmem = dm;
        req_addr = a; req_wdata = wd; req_ext = ext;
        e.write = wr; e.dmem = dm; e.addr = a;
        e.data  = wr ? wd : mem_val(a);
        e.dslen = (wr ? 1 : 2) + (ext ? 2 : 0);
        sb.push_back(e);
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Bus model and monitor
    logic [15:0] lat_addr;
    logic        lat_rw, lat_dsel;
    logic [7:0]  lat_wd;
    int          lo_cnt = 0, last_len = 0;
    logic        prev_as = 1'b1, prev_ds = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_as && !as_n) begin
                as_falls++;
                lat_addr = {addr_hi, ad_out};
                lat_rw   = rw_n;
                lat_dsel = dsel;
                check(ad_oe == 1'b1, "R2 oe at as fall", ad_oe, 1);
            end
            if (!ds_n) begin
                lo_cnt++;
                check(as_n == 1'b1, "R9 as high in ds low", as_n, 1);
                if (rw_n) begin
                    check(ad_oe == 1'b0, "R4 port released", ad_oe, 0);
                    ad_in = mem_val(lat_addr);
                end else begin
                    check(ad_oe == 1'b1, "R5 write drive", ad_oe, 1);
                    lat_wd = ad_out;
                end
            end else begin
                ad_in = 8'h00;
            end
            if (!prev_ds && ds_n) begin
                last_len = lo_cnt;
                lo_cnt = 0;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 extra transfer", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(lat_addr == e.addr, "R2/R10 address", lat_addr, e.addr);
                    check(lat_rw == !e.write, "R3 rw_n", lat_rw, !e.write);
                    check(lat_dsel == e.dmem, "R3 dsel", lat_dsel, e.dmem);
                    check(last_len == e.dslen, "R6 ds length", last_len, e.dslen);
                    check(prev_ds == 1'b0 && ds_n == 1'b1, "R8 done after ds rise", prev_ds, 0);
                    check(addr_hi == e.addr[15:8], "R10 hi held", addr_hi, e.addr[15:8]);
                    if (e.write) begin
                        check(lat_wd == e.data, "R5 write data", lat_wd, e.data);
                        check(ad_oe && ad_out == e.data, "R5 hold after ds", ad_out, e.data);
                    end else begin
                        check(rd_data == e.data, "R7 read capture", rd_data, e.data);
                    end
                end
            end
        end
        prev_as = as_n;
        prev_ds = ds_n;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(as_n && ds_n && !ad_oe, "R1 strobes idle in reset", {as_n, ds_n, ad_oe}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(done == 1'b0 && rw_n == 1'b1 && dsel == 1'b0, "R1 ctl idle", {done, rw_n, dsel}, 3'b010);
        check(addr_hi == 8'h00, "R1 addr_hi", addr_hi, 0);

        do_req(1'b0, 1'b1, 16'h12A5, 8'h00, 1'b0);
        do_req(1'b1, 1'b0, 16'hBEEF, 8'h3C, 1'b0);
        do_req(1'b0, 1'b0, 16'h00FF, 8'h00, 1'b1);
        do_req(1'b1, 1'b1, 16'hFF00, 8'hC3, 1'b1);

        // R8 ready low while busy, R9 ignore requests while busy
        do_req(1'b0, 1'b1, 16'h4321, 8'h00, 1'b0);
        check(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h9999; req_wdata = 8'h77;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        check(as_falls == issued, "R9 no extra cycle", as_falls, issued);
        check(rd_data == mem_val(16'h4321), "R7 data held", rd_data, mem_val(16'h4321));

        for (int i = 0; i < 6; i++) begin
            do_req(i[0], i[1], 16'(i * 16'h1357 + 16'h0101), 8'(i * 37), i[2]);
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R8 all done", sb.size(), 0);
        check(as_n && ds_n && !ad_oe && req_ready, "R1 idle after traffic",
              {as_n, ds_n, ad_oe, req_ready}, 4'b1101);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule